// File: doc/BRIEF.md
# Indexed Block-Access I2C Configuration Register Slave

This block is an I2C target that exposes a bank of fifteen 8-bit configuration bytes to a host controller. Every transfer begins by writing a starting index. A write then carries a byte-count byte followed by data, which is stored at consecutive locations. A read turns the bus around with a repeated start, then returns the stored byte count followed by data from the starting index onward, until the host signals that it has had enough. The index advances after each data byte and wraps to zero after the last location.

All bus activity is oversampled by the system clock. SCL and SDA pass through synchronizers and an edge detector. The open-drain SDA pin appears as a separate input, an output tied low, and an output enable that pulls the line low. The whole register view is presented on a parallel bus, so that neighbouring logic can decode its fields directly.

Some fields are not stored. They are merged into the view from input pins: five latched frequency-select straps, a current-multiplier strap and a four-bit revision code. Writes to these fields, and to reserved bits, are acknowledged but leave the stored value unchanged.

Top module: `i2c_idx_regbank`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the slave ignores the bus until the next start condition.
- R2: A write transaction has the form start, 0xD2, index N, count X, then data bytes. The slave acknowledges every byte and stores the data bytes at N, N+1, … up to X of them.
- R3: Data bytes that arrive after X bytes have been stored are still acknowledged, but they change nothing.
- R4: A read transaction has the form start, 0xD2, index N, repeated start, 0xD3. The slave then sends byte 7, followed by bytes N, N+1, … Bytes go out MSB first while the host acknowledges. After the host's NACK the slave releases SDA.
- R5: After reset the stored values are: byte 1 low bits 3'b111, byte 2 0xFF, byte 7 0x0F, byte 10 0x1F, and every other stored bit 0.
- R6: Byte 1 bits 7:3 reflect the frequency-select straps. Byte 4 bit 7 reflects the multiplier strap. Byte 8 reads {revision[3:0], 4'b0001}. All of these follow their pins.
- R7: A write to a read-only or reserved bit leaves it unchanged but is acknowledged. The protected bits are byte 1 bits 7:3, all of bytes 4, 6 and 8, and byte 14 bits 7:5.
- R8: The index wraps from 14 to 0. An index byte of 15 or more selects location 0.
- R9: SDA is sampled on rising SCL. A start (SDA falling) or a stop (SDA rising) is recognised while SCL is high, and a stop abandons the transaction. The slave changes SDA only while SCL is low.
- R10: Byte i of the register view, including merged strap fields, appears on cfg_q[8i+7:8i].
- R11: Byte 7 is writable, and the count sent at the start of a read is its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_o | output | 1 | Data output level, always 0 (open drain) |
| sda_oe | output | 1 | High to pull SDA low |
| fsel_strap | input | 5 | Latched frequency-select strap values |
| mult_strap | input | 1 | Latched current-multiplier strap |
| rev_id | input | 4 | Revision code merged into byte 8 |
| cfg_q | output | 120 | Parallel register view, byte i at bits 8i+7:8i |

## Verification
The bench drives blocks that cross the wrap point, as well as an index beyond the bank. A design with a wrong wrap would write past location 14 or into the wrong byte. It sends more data bytes than the count allows and writes all ones over the protected fields. A design that ignored the count or the masks would corrupt bytes 4, 6, 8, 10 or 14, which the per-clock comparison against the reference register image shows at once. Reads check that the count byte comes first and reflects a rewritten byte 7, and that SDA is released after the host's NACK. A stray address must get no acknowledge and must leave every byte untouched, and the bench watches that SDA never moves while SCL is high.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;
   localparam int NUM_BYTES_DEF = 15;
   localparam int FSEL_W        = 5;
   localparam int REV_W         = 4;
   localparam int CNT_IDX       = 7;
   localparam int FSEL_IDX      = 1;
   localparam int MULT_IDX      = 4;
   localparam int VEND_IDX      = 8;
   localparam logic [3:0] VENDOR_NIB = 4'b0001;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } bus_state_t;

   // bits a host write may change, per location
   function automatic logic [7:0] wr_mask(input int i);
      case (i)
         1:        return 8'h07;
         4, 6, 8:  return 8'h00;
         14:       return 8'h1F;
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(input int i);
      case (i)
         1:       return 8'h07;
         2:       return 8'hFF;
         7:       return 8'h0F;
         10:      return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/i2crb_sync.sv
module i2crb_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2crb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2crb_events.sv
module i2crb_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/i2crb_bank.sv
module i2crb_bank
   import i2crb_pkg::*;
#(
   parameter int NUM   = NUM_BYTES_DEF,
   parameter int IDX_W = $clog2(NUM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [FSEL_W-1:0] fsel_strap,
   input  logic              mult_strap,
   input  logic [REV_W-1:0]  rev_id,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data,
   output logic [NUM*8-1:0]  view_bus
);
   logic [7:0] store_q [NUM];
   logic [7:0] view_a  [NUM];

   generate
      for (genvar g = 0; g < NUM; g++) begin : g_loc
         localparam logic [7:0] MASK = wr_mask(g);
         localparam logic [7:0] INIT = rst_val(g);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store_q[g] <= INIT;
            else if (wr_en && wr_idx == IDX_W'(g))
               store_q[g] <= (store_q[g] & ~MASK) | (wr_data & MASK);
         end

         // protected bits stay at their reset value of 0, so merge by OR
         if (g == FSEL_IDX) begin : g_fsel
            assign view_a[g] = store_q[g] | {fsel_strap, 3'b000};
         end else if (g == MULT_IDX) begin : g_mult
            assign view_a[g] = store_q[g] | {mult_strap, 7'b0};
         end else if (g == VEND_IDX) begin : g_vend
            assign view_a[g] = store_q[g] | {rev_id, VENDOR_NIB};
         end else begin : g_plain
            assign view_a[g] = store_q[g];
         end

         assign view_bus[g*8 +: 8] = view_a[g];
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM; i++)
         if (rd_idx == IDX_W'(i)) rd_data = view_a[i];
   end

   AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_idx} < (IDX_W+1)'(NUM))) else $error("write index out of bank"); // R8
endmodule

// File: rtl/i2crb_ctrl.sv
module i2crb_ctrl
   import i2crb_pkg::*;
#(
   parameter int         NUM     = NUM_BYTES_DEF,
   parameter int         IDX_W   = $clog2(NUM),
   parameter logic [6:0] DEV_ADR = 7'h69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             drv_low
);
   localparam logic [7:0]       WR_ADR8 = {DEV_ADR, 1'b0};
   localparam logic [7:0]       RD_ADR8 = {DEV_ADR, 1'b1};
   localparam logic [7:0]       NUM8    = 8'(NUM);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM - 1);

   bus_state_t       st;
   logic [2:0]       bitcnt;
   logic             full;
   logic [7:0]       sh;
   logic             rw;
   logic [1:0]       phase;
   logic [7:0]       remain;
   logic [IDX_W-1:0] idx, idx_nxt;
   logic             host_ack;

   assign idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
   assign rd_idx  = (st == ST_ADDR_ACK) ? IDX_W'(CNT_IDX) : idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  bitcnt <= '0;  full <= 1'b0;  sh <= '0;
         rw <= 1'b0;     phase <= '0;   remain <= '0;  idx <= '0;
         host_ack <= 1'b0;  drv_low <= 1'b0;
         wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st <= ST_ADDR;  bitcnt <= '0;  full <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;  full <= 1'b0;
         end else if (scl_rise) begin
            case (st)
               ST_ADDR, ST_RX: begin
                  sh     <= {sh[6:0], sda_s};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) full <= 1'b1;
               end
               ST_TX: begin
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) full <= 1'b1;
               end
               ST_TX_ACK: host_ack <= ~sda_s;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (st)
               ST_IDLE: drv_low <= 1'b0;
               ST_ADDR: if (full) begin
                  full <= 1'b0;  bitcnt <= '0;
                  if (sh == WR_ADR8) begin
                     rw <= 1'b0;  drv_low <= 1'b1;  st <= ST_ADDR_ACK;
                  end else if (sh == RD_ADR8) begin
                     rw <= 1'b1;  drv_low <= 1'b1;  st <= ST_ADDR_ACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               ST_ADDR_ACK: if (!rw) begin
                  drv_low <= 1'b0;  phase <= 2'd0;  st <= ST_RX;
               end else begin
                  sh <= rd_data;  drv_low <= ~rd_data[7];  st <= ST_TX;
               end
               ST_RX: if (full) begin
                  full <= 1'b0;  bitcnt <= '0;  drv_low <= 1'b1;  st <= ST_RX_ACK;
                  case (phase)
                     2'd0: begin
                        idx   <= (sh < NUM8) ? sh[IDX_W-1:0] : '0;
                        phase <= 2'd1;
                     end
                     2'd1: begin
                        remain <= sh;
                        phase  <= 2'd2;
                     end
                     default: if (remain != 8'd0) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= sh;
                        idx     <= idx_nxt;
                        remain  <= remain - 8'd1;
                     end
                  endcase
               end
               ST_RX_ACK: begin
                  drv_low <= 1'b0;  st <= ST_RX;
               end
               ST_TX: if (full) begin
                  full <= 1'b0;  bitcnt <= '0;  drv_low <= 1'b0;  st <= ST_TX_ACK;
               end else begin
                  sh <= {sh[6:0], 1'b0};  drv_low <= ~sh[6];
               end
               ST_TX_ACK: if (host_ack) begin
                  sh <= rd_data;  drv_low <= ~rd_data[7];  idx <= idx_nxt;  st <= ST_TX;
               end else begin
                  drv_low <= 1'b0;  st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drv_low) |-> !scl_s) else $error("SDA changed with SCL high"); // R9
   AST_IDX_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, idx} < (IDX_W+1)'(NUM)) else $error("index left the bank"); // R8
   AST_WR_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (st == ST_RX_ACK && drv_low)) else $error("store outside ack slot"); // R2
   AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RX_ACK && scl_fall) |=> (st == ST_RX && !drv_low)) else $error("ack not released"); // R2
   AST_NOMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_ADDR) |-> !drv_low) else $error("drive after foreign address"); // R1
endmodule

// File: rtl/i2c_idx_regbank.sv
module i2c_idx_regbank
   import i2crb_pkg::*;
#(
   parameter int         NUM_BYTES   = NUM_BYTES_DEF,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADR     = 7'h69
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_o,
   output logic                  sda_oe,
   input  logic [FSEL_W-1:0]     fsel_strap,
   input  logic                  mult_strap,
   input  logic [REV_W-1:0]      rev_id,
   output logic [NUM_BYTES*8-1:0] cfg_q
);
   localparam int IDX_W = $clog2(NUM_BYTES);

   generate
      if (NUM_BYTES <= VEND_IDX || NUM_BYTES > 256) begin : g_bad_size
         $error("i2c_idx_regbank: NUM_BYTES must cover the fixed fields and fit an index byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0]       rd_data, wr_data;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic             wr_en, drv_low;

   i2crb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2crb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2crb_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2crb_ctrl #(.NUM(NUM_BYTES), .IDX_W(IDX_W), .DEV_ADR(DEV_ADR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .drv_low(drv_low));

   i2crb_bank #(.NUM(NUM_BYTES), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .fsel_strap(fsel_strap), .mult_strap(mult_strap), .rev_id(rev_id),
      .rd_idx(rd_idx), .rd_data(rd_data), .view_bus(cfg_q));

   assign sda_o  = 1'b0;
   assign sda_oe = drv_low;
endmodule

// File: tb/i2c_idx_regbank_tb.sv
module i2c_idx_regbank_tb;
   localparam int NB = 15;
   localparam int Q  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1;
   logic [4:0] fsel = 5'b10110;
   logic       mult = 1'b1;
   logic [3:0] rev  = 4'hA;
   logic       sda_o, sda_oe;
   logic [NB*8-1:0] cfg_q;
   wire        sda_line = sda_h & ~sda_oe;

   int checks = 0, errors = 0;
   bit busy = 1'b1;
   bit done = 1'b0;
   logic [7:0] mem [NB];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];
   logic [7:0] rcount;

   always #10 clk = ~clk;

   i2c_idx_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe),
      .fsel_strap(fsel), .mult_strap(mult), .rev_id(rev), .cfg_q(cfg_q));

   function automatic logic [7:0] mmask(input int i);
      case (i)
         1:       return 8'h07;
         4, 6, 8: return 8'h00;
         14:      return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] view(input int i);
      logic [7:0] m;
      m = mem[i];
      if (i == 1) m[7:3] = fsel;
      if (i == 4) m[7] = mult;
      if (i == 8) m = {rev, 4'b0001};
      return m;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference image compared with the register view every clock (R10)
   always @(negedge clk) begin
      if (rst_n && !busy && !done) begin
         for (int i = 0; i < NB; i++) begin
            checks++;
            if (cfg_q[i*8 +: 8] !== view(i)) begin
               errors++;
               $display("FAIL R10 byte %0d actual=%0h expected=%0h", i, cfg_q[i*8 +: 8], view(i));
            end
         end
      end
   end

   // SDA must not move while SCL is high (R9)
   logic oe_p = 1'b0, scl_p = 1'b1;
   always @(negedge clk) begin
      if (rst_n && !done && sda_oe !== oe_p) begin
         checks++;
         if (scl_p && scl_h) begin
            errors++;
            $display("FAIL R9 sda_oe moved with SCL high actual=%0b expected=%0b", sda_oe, oe_p);
         end
      end
      oe_p  = sda_oe;
      scl_p = scl_h;
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b0; wq(Q); scl_h = 1'b0; wq(Q);
   endtask

   task automatic bus_rstart();
      sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl_h = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_h = b; wq(Q); scl_h = 1'b1; wq(2*Q); scl_h = 1'b0; wq(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q); b = sda_line; wq(Q); scl_h = 1'b0; wq(Q);
   endtask

   task automatic put_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int k = 7; k >= 0; k--) send_bit(d[k]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(input logic ack, output logic [7:0] d);
      logic b;
      for (int k = 7; k >= 0; k--) begin
         recv_bit(b);
         d[k] = b;
      end
      send_bit(~ack);
   endtask

   // block write of len bytes from wbuf, announced count cnt
   task automatic blk_write(input int n, input int cnt, input int len, input string tag);
      logic a;
      int   ix;
      busy = 1'b1;
      bus_start();
      put_byte(8'hD2, a); chk({tag, " R1 write address ack"}, a, 1);
      put_byte(8'(n), a);  chk({tag, " R2 index ack"}, a, 1);
      put_byte(8'(cnt), a); chk({tag, " R2 count ack"}, a, 1);
      for (int k = 0; k < len; k++) begin
         put_byte(wbuf[k], a);
         chk({tag, (k < cnt) ? " R2 data ack" : " R3 surplus ack"}, a, 1);
      end
      bus_stop();
      ix = (n < NB) ? n : 0;
      for (int k = 0; k < len && k < cnt; k++) begin
         mem[ix] = (mem[ix] & ~mmask(ix)) | (wbuf[k] & mmask(ix));
         ix = (ix == NB - 1) ? 0 : ix + 1;
      end
      wq(4);
      busy = 1'b0;
   endtask

   // block read of len data bytes into rbuf, count into rcount
   task automatic blk_read(input int n, input int len, input string tag);
      logic a;
      bus_start();
      put_byte(8'hD2, a); chk({tag, " R1 write address ack"}, a, 1);
      put_byte(8'(n), a);  chk({tag, " R4 index ack"}, a, 1);
      bus_rstart();
      put_byte(8'hD3, a); chk({tag, " R1 read address ack"}, a, 1);
      get_byte(1'b1, rcount);
      for (int k = 0; k < len; k++) get_byte(k != len - 1, rbuf[k]);
      chk({tag, " R4 SDA released after NACK"}, int'(sda_oe), 0);
      bus_stop();
      wq(4);
   endtask

   task automatic expect_read(input int n, input int len, input string tag);
      int ix;
      blk_read(n, len, tag);
      chk({tag, " R11 count byte"}, rcount, view(7));
      ix = (n < NB) ? n : 0;
      for (int k = 0; k < len; k++) begin
         chk({tag, " R4 data byte"}, rbuf[k], view(ix));
         ix = (ix == NB - 1) ? 0 : ix + 1;
      end
   endtask

   initial begin
      logic a;
      for (int i = 0; i < NB; i++) mem[i] = 8'h00;
      mem[1] = 8'h07; mem[2] = 8'hFF; mem[7] = 8'h0F; mem[10] = 8'h1F;
      wq(5);
      rst_n = 1'b1;
      wq(5);
      busy = 1'b0;

      // R5, R6: reset image and strap merge
      chk("R5 byte0 reset", cfg_q[0 +: 8], 8'h00);
      chk("R5 byte2 reset", cfg_q[16 +: 8], 8'hFF);
      chk("R5 byte7 reset", cfg_q[56 +: 8], 8'h0F);
      chk("R5 byte10 reset", cfg_q[80 +: 8], 8'h1F);
      chk("R6 byte1 straps", cfg_q[8 +: 8], {5'b10110, 3'b111});
      chk("R6 byte4 strap", cfg_q[32 +: 8], 8'h80);
      chk("R6 byte8 vendor", cfg_q[64 +: 8], 8'hA1);
      chk("R9 idle no drive", int'(sda_oe), 0);

      // R2: plain block write then read back
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
      blk_write(3, 3, 3, "wr3");
      chk("R2 byte3", cfg_q[24 +: 8], 8'hA5);
      chk("R2 byte5", cfg_q[40 +: 8], 8'hC3);
      expect_read(3, 3, "rd3");

      // R7: all ones over protected locations 4..8 (byte 7 writable)
      for (int k = 0; k < 5; k++) wbuf[k] = 8'hFF;
      blk_write(4, 5, 5, "ro");
      chk("R7 byte4 protected", cfg_q[32 +: 8], 8'h80);
      chk("R7 byte6 reserved", cfg_q[48 +: 8], 8'h00);
      chk("R7 byte8 vendor", cfg_q[64 +: 8], 8'hA1);
      wbuf[0] = 8'hFF; blk_write(1, 1, 1, "ro1");
      chk("R7 byte1 straps kept", cfg_q[8 +: 8], {5'b10110, 3'b111});

      // R11: rewritten count is what a read sends first
      wbuf[0] = 8'h05; blk_write(7, 1, 1, "cnt");
      expect_read(0, 2, "rdcnt");

      // R8: wrap past the last location, masked byte 14
      wbuf[0] = 8'h11; wbuf[1] = 8'hEE; wbuf[2] = 8'h77;
      blk_write(13, 3, 3, "wrap");
      chk("R8 byte14 masked", cfg_q[112 +: 8], 8'h0E);
      chk("R8 wrapped to byte0", cfg_q[0 +: 8], 8'h77);
      expect_read(14, 3, "rdwrap");

      // R8: out-of-range index selects location 0
      wbuf[0] = 8'h66; blk_write(8'h20, 1, 1, "oor");
      chk("R8 index>=15 to byte0", cfg_q[0 +: 8], 8'h66);

      // R3: bytes beyond the count are acknowledged but dropped
      wbuf[0] = 8'h3C; wbuf[1] = 8'h99; wbuf[2] = 8'h42;
      blk_write(9, 1, 3, "surplus");
      chk("R3 byte9 stored", cfg_q[72 +: 8], 8'h3C);
      chk("R3 byte10 untouched", cfg_q[80 +: 8], 8'h1F);

      // R1: foreign address gets no ack and writes nothing
      busy = 1'b1;
      bus_start();
      put_byte(8'hA0, a); chk("R1 foreign address nack", a, 0);
      put_byte(8'h00, a); chk("R1 ignored byte nack", a, 0);
      put_byte(8'h01, a); chk("R1 ignored byte nack", a, 0);
      put_byte(8'hDE, a);
      bus_stop();
      wq(4);
      busy = 1'b0;
      chk("R1 byte0 untouched", cfg_q[0 +: 8], 8'h66);

      // R6: strap inputs follow pins; readable through the bus
      busy = 1'b1;
      fsel = 5'b01001; mult = 1'b0; rev = 4'h3;
      wq(2);
      busy = 1'b0;
      chk("R6 byte1 new straps", cfg_q[8 +: 8], {5'b01001, 3'b111});
      chk("R6 byte8 new rev", cfg_q[64 +: 8], 8'h31);
      wbuf[0] = 8'h00; blk_write(1, 1, 1, "clr1");
      chk("R6 byte1 low bits cleared", cfg_q[8 +: 8], {5'b01001, 3'b000});
      expect_read(1, 8, "rdstrap");

      // R9: stop in the middle abandons the write
      busy = 1'b1;
      bus_start();
      put_byte(8'hD2, a);
      put_byte(8'h0B, a);
      bus_stop();
      bus_start();
      put_byte(8'h55, a); chk("R9 stop abandoned transfer", a, 0);
      bus_stop();
      wq(4);
      busy = 1'b0;
      chk("R9 byte11 untouched", cfg_q[88 +: 8], 8'h00);

      wq(10);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule